// File: doc/BRIEF.md
# Host-to-Slave Mailbox Channel

This block is one channel of a parallel host port. An external host processor reaches it through an active-low chip select, an active-low read strobe, an active-low write strobe, one address line and an 8-bit data bus. An internal slave processor reaches it through a small synchronous register bus. The host writes bytes into an inbound register. The slave answers through an outbound register. A status byte carries two handshake flags, a command/data marker and a few general-purpose bits for the slave.

The host pins are asynchronous to the slave clock. Each host access is first synchronized. It is then reduced to a single one-cycle event, so a flag changes exactly once per access, however long the strobe is held. The host data bus is shown as a data-out vector plus an output enable. The output enable is meant to feed a tri-state pad outside this block.

Slave register addresses: 0 is the inbound register (read only), 1 is the outbound register, 2 is status. Status layout: bit 0 is outbound-full (OBF), bit 1 is inbound-full (IBF), bit 3 is the command/data marker (CD), and bits 7..4 and 2 are user bits.

Top module: `hif_mailbox`

## Requirements
- R1: After reset the status byte is 0x00, and the host data bus is not driven while the host is idle.
- R2: `hostDataOe` is 1 exactly while `hostCsN` and `hostRdN` are both 0. While it is 1, `hostDataOut` carries the outbound register when `hostA0` is 0 and the status byte when `hostA0` is 1.
- R3: A host write with `hostCsN` at 0, for either value of `hostA0`, loads `hostDataIn` into the inbound register and sets IBF (status bit 1). Both take effect on the third rising clock edge after the strobe is first seen low.
- R4: On each host write, CD (status bit 3) takes the value of `hostA0`: 0 means data and 1 means command.
- R5: A slave read of address 0 returns the inbound register and clears IBF. If a host write lands in the same cycle, IBF ends up set.
- R6: A slave write to address 1 loads the outbound register and sets OBF (status bit 0). A host read with `hostA0` at 0 clears OBF. A host read with `hostA0` at 1 leaves OBF unchanged. If a slave write and an OBF-clearing host read fall in the same cycle, OBF ends up set.
- R7: A slave write to address 2 sets bits 7..4 and bit 2 to the written values. It leaves CD and IBF unchanged.
- R8: In a slave status write, a 0 in bit 0 clears OBF and a 1 in bit 0 leaves OBF unchanged.
- R9: Each host access acts once, even when the strobe is held for many cycles. An access with `hostCsN` at 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostA0 | input | 1 | Host address line: data/command on writes, outbound/status on reads |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | Host data bus drive enable |
| slvAddr | input | 2 | Slave register select |
| slvRd | input | 1 | Slave read strobe, one cycle |
| slvWr | input | 1 | Slave write strobe, one cycle |
| slvWdata | input | 8 | Slave write data |
| slvRdata | output | 8 | Slave read data (combinational) |

## Verification
Two pairs of events can fall in the same cycle: a host write's IBF set with a slave read of the inbound register, and a host outbound read's OBF clear with a slave write of the outbound register. The bench provokes each one by starting the host access and the slave strobe in parallel branches. It times the slave strobe to the edge on which the synchronized host event fires, three edges after the host strobe. The behavioural model resolves each such cycle by the priorities in R5 and R6. A directed check with a hard-coded status value then confirms that the flag was left set.

// File: rtl/hif_mbx_pkg.sv
package hif_mbx_pkg;
  localparam int DATA_W   = 8;
  localparam int SADDR_W  = 2;
  localparam int STAT_OBF = 0;
  localparam int STAT_IBF = 1;
  localparam int STAT_CD  = 3;
  localparam logic [DATA_W-1:0] USER_MASK = 8'hF4;
  localparam logic [SADDR_W-1:0] ADDR_IN   = 2'd0;
  localparam logic [SADDR_W-1:0] ADDR_OUT  = 2'd1;
  localparam logic [SADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic hostWrLoad;
    logic hostRdOut;
    logic slvRdIn;
    logic slvWrOut;
    logic slvWrStat;
  } mbxStrobes_t;
endpackage

// File: rtl/hif_mbx_edge.sv
module hif_mbx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic activeAsync,
  output logic pulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;
  logic [CHAIN_W-1:0] chainQ;

  always_ff @(posedge clk) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[CHAIN_W-2:0], activeAsync};
  end

  assign pulse = chainQ[SYNC_STAGES-1] & ~chainQ[SYNC_STAGES];

  // One event per access: a pulse never spans two cycles (R9)
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);
endmodule

// File: rtl/hif_mbx_ctrl.sv
module hif_mbx_ctrl
  import hif_mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCsN,
  input  logic               hostA0,
  input  logic               hostRdN,
  input  logic               hostWrN,
  input  logic [SADDR_W-1:0] slvAddr,
  input  logic               slvRd,
  input  logic               slvWr,
  output mbxStrobes_t        strobes
);
  localparam int NUM_HOST_EV = 2;
  logic [NUM_HOST_EV-1:0] hostActive;
  logic [NUM_HOST_EV-1:0] hostPulse;

  assign hostActive[0] = ~hostCsN & ~hostWrN;
  assign hostActive[1] = ~hostCsN & ~hostRdN;

  for (genvar i = 0; i < NUM_HOST_EV; i++) begin : g_sync
    hif_mbx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rstN       (rstN),
      .activeAsync(hostActive[i]),
      .pulse      (hostPulse[i])
    );
  end

  always_comb begin
    strobes.hostWrLoad = hostPulse[0];
    strobes.hostRdOut  = hostPulse[1] & ~hostA0;
    strobes.slvRdIn    = slvRd & (slvAddr == ADDR_IN);
    strobes.slvWrOut   = slvWr & (slvAddr == ADDR_OUT);
    strobes.slvWrStat  = slvWr & (slvAddr == ADDR_STAT);
  end
endmodule

// File: rtl/hif_mbx_datapath.sv
module hif_mbx_datapath
  import hif_mbx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  mbxStrobes_t        strobes,
  input  logic               hostCsN,
  input  logic               hostA0,
  input  logic               hostRdN,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic               hostDataOe,
  input  logic [SADDR_W-1:0] slvAddr,
  input  logic [DATA_W-1:0]  slvWdata,
  output logic [DATA_W-1:0]  slvRdata
);
  logic [DATA_W-1:0] inRegQ, outRegQ, userQ, statusVal;
  logic cdQ, ibfQ, obfQ;

  // Data registers carry no reset value
  always_ff @(posedge clk) begin
    if (strobes.hostWrLoad) inRegQ  <= hostDataIn;
    if (strobes.slvWrOut)   outRegQ <= slvWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userQ <= '0;
      cdQ   <= 1'b0;
      ibfQ  <= 1'b0;
      obfQ  <= 1'b0;
    end else begin
      if (strobes.slvWrStat) userQ <= slvWdata & USER_MASK;
      if (strobes.hostWrLoad) cdQ <= hostA0;
      if (strobes.hostWrLoad)   ibfQ <= 1'b1;
      else if (strobes.slvRdIn) ibfQ <= 1'b0;
      if (strobes.slvWrOut) obfQ <= 1'b1;
      else if (strobes.hostRdOut || (strobes.slvWrStat && !slvWdata[STAT_OBF]))
        obfQ <= 1'b0;
    end
  end

  always_comb begin
    statusVal = userQ;
    statusVal[STAT_CD]  = cdQ;
    statusVal[STAT_IBF] = ibfQ;
    statusVal[STAT_OBF] = obfQ;
  end

  always_comb begin
    unique case (slvAddr)
      ADDR_IN:   slvRdata = inRegQ;
      ADDR_OUT:  slvRdata = outRegQ;
      ADDR_STAT: slvRdata = statusVal;
      default:   slvRdata = '0;
    endcase
  end

  assign hostDataOe  = ~hostCsN & ~hostRdN;
  assign hostDataOut = hostA0 ? statusVal : outRegQ;

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hostWrLoad |=> ibfQ);
  assert_cd_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hostWrLoad |=> cdQ == $past(hostA0));
  assert_ibf_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slvRdIn && !strobes.hostWrLoad) |=> !ibfQ);
  assert_obf_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slvWrOut |=> obfQ);
  assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slvWrStat && !strobes.hostWrLoad && !strobes.slvRdIn)
      |=> (cdQ == $past(cdQ)) && (ibfQ == $past(ibfQ)));
  assert_obf_write1_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slvWrStat && slvWdata[STAT_OBF] && !strobes.hostRdOut && !strobes.slvWrOut)
      |=> obfQ == $past(obfQ));
endmodule

// File: rtl/hif_mailbox.sv
module hif_mailbox
  import hif_mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCsN,
  input  logic               hostA0,
  input  logic               hostRdN,
  input  logic               hostWrN,
  input  logic [DATA_W-1:0]  hostDataIn,
  output logic [DATA_W-1:0]  hostDataOut,
  output logic               hostDataOe,
  input  logic [SADDR_W-1:0] slvAddr,
  input  logic               slvRd,
  input  logic               slvWr,
  input  logic [DATA_W-1:0]  slvWdata,
  output logic [DATA_W-1:0]  slvRdata
);
  mbxStrobes_t strobes;

  hif_mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostA0(hostA0),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .slvAddr(slvAddr),
    .slvRd(slvRd), .slvWr(slvWr), .strobes(strobes)
  );

  hif_mbx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostCsN(hostCsN),
    .hostA0(hostA0), .hostRdN(hostRdN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .slvAddr(slvAddr),
    .slvWdata(slvWdata), .slvRdata(slvRdata)
  );
endmodule

// File: tb/hif_mailbox_bench.sv
module hif_mailbox_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostA0 = 1'b0, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [7:0] hostDataIn = '0;
  logic [7:0] hostDataOut;
  logic hostDataOe;
  logic [1:0] slvAddr = 2'd2;
  logic slvRd = 1'b0, slvWr = 1'b0;
  logic [7:0] slvWdata = '0;
  logic [7:0] slvRdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hif_mailbox u_hif_mailbox (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostA0(hostA0),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .slvAddr(slvAddr),
    .slvRd(slvRd), .slvWr(slvWr), .slvWdata(slvWdata), .slvRdata(slvRdata)
  );

  // Reference model
  typedef struct { int due; bit wr; bit a0; logic [7:0] d; } hostEv_t;
  hostEv_t evQ[$];
  logic [7:0] mIn, mOut, mUser;
  bit mInKnown = 0, mOutKnown = 0, mCd, mIbf, mObf;

  function automatic logic [7:0] mStatus();
    return {mUser[7:4], mCd, mUser[2], mIbf, mObf};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    hostEv_t ev;
    bit hw, hr0;
    bit ibfN, obfN;
    cyc++;
    if (!rstN) begin
      mUser = '0; mCd = 0; mIbf = 0; mObf = 0;
    end else begin
      hw = 0; hr0 = 0;
      while (evQ.size() > 0 && evQ[0].due == cyc) begin
        ev = evQ.pop_front();
        if (ev.wr) begin
          hw = 1; mIn = ev.d; mInKnown = 1; mCd = ev.a0;
        end else if (!ev.a0) hr0 = 1;
      end
      ibfN = mIbf;
      if (slvRd && slvAddr == 2'd0) ibfN = 0;
      if (hw) ibfN = 1;
      obfN = mObf;
      if (hr0) obfN = 0;
      if (slvWr && slvAddr == 2'd2) begin
        mUser = slvWdata & 8'hF4;
        if (!slvWdata[0]) obfN = 0;
      end
      if (slvWr && slvAddr == 2'd1) begin
        obfN = 1; mOut = slvWdata; mOutKnown = 1;
      end
      mIbf = ibfN; mObf = obfN;
    end
  end

  // Per-clock comparison, away from edges
  always @(negedge clk) begin
    logic [7:0] s;
    #5;
    if (rstN && !done) begin
      s = mStatus();
      chk(hostDataOe == (!hostCsN && !hostRdN), "R2_oe", hostDataOe, !hostCsN && !hostRdN);
      if (hostDataOe && hostA0) chk(hostDataOut == s, "R2_stat", hostDataOut, s);
      if (hostDataOe && !hostA0 && mOutKnown) chk(hostDataOut == mOut, "R2_out", hostDataOut, mOut);
      if (slvAddr == 2'd2) begin
        chk(slvRdata[0] == s[0], "R6_obf", slvRdata[0], s[0]);
        chk(slvRdata[1] == s[1], "R5_ibf", slvRdata[1], s[1]);
        chk(slvRdata[3] == s[3], "R4_cd", slvRdata[3], s[3]);
        chk((slvRdata & 8'hF4) == (s & 8'hF4), "R7_user", slvRdata, s);
      end
      if (slvAddr == 2'd0 && mInKnown) chk(slvRdata == mIn, "R3_in", slvRdata, mIn);
      if (slvAddr == 2'd1 && mOutKnown) chk(slvRdata == mOut, "R6_out", slvRdata, mOut);
    end
  end

  task automatic hostAcc(input bit wr, input bit a0, input logic [7:0] d,
                         input int hold, input bit csOn,
                         input bit chkData, input logic [7:0] expData);
    @(negedge clk);
    hostCsN = !csOn; hostA0 = a0; hostDataIn = d;
    if (wr) hostWrN = 0; else hostRdN = 0;
    if (csOn) evQ.push_back('{due: cyc + 3, wr: wr, a0: a0, d: d});
    #5;
    if (!wr) chk(hostDataOe == csOn, "R2_oe_dir", hostDataOe, csOn);
    if (chkData) chk(hostDataOut == expData, "R2_data_dir", hostDataOut, expData);
    repeat (hold) @(negedge clk);
    hostWrN = 1; hostRdN = 1; hostCsN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic slvRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    slvAddr = a; slvRd = 1;
    #5 v = slvRdata;
    @(negedge clk);
    slvRd = 0; slvAddr = 2'd2;
  endtask

  task automatic slvWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    slvAddr = a; slvWdata = d; slvWr = 1;
    @(negedge clk);
    slvWr = 0; slvAddr = 2'd2;
  endtask

  task automatic expStat(input logic [7:0] e, input string tag);
    @(negedge clk);
    slvAddr = 2'd2;
    #5 chk(slvRdata == e, tag, slvRdata, e);
  endtask

  task automatic runTests();
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    expStat(8'h00, "R1_reset_status");
    chk(hostDataOe == 0, "R1_idle_oe", hostDataOe, 0);

    hostAcc(1, 0, 8'h5A, 4, 1, 0, 0);
    expStat(8'h02, "R3_ibf_set");
    slvRead(2'd0, v);
    chk(v == 8'h5A, "R3_in_data", v, 8'h5A);
    expStat(8'h00, "R5_ibf_clear");

    hostAcc(1, 1, 8'hC3, 4, 1, 0, 0);
    expStat(8'h0A, "R4_cd_command");
    slvRead(2'd0, v);
    chk(v == 8'hC3, "R3_in_cmd", v, 8'hC3);
    expStat(8'h08, "R5_clear_keep_cd");

    slvWrite(2'd1, 8'h96);
    expStat(8'h09, "R6_obf_set");
    hostAcc(0, 1, 8'h00, 4, 1, 1, 8'h09);
    expStat(8'h09, "R6_status_read_keeps");
    hostAcc(0, 0, 8'h00, 4, 1, 1, 8'h96);
    expStat(8'h08, "R6_obf_clear");
    hostAcc(0, 0, 8'h00, 4, 0, 0, 0);

    slvWrite(2'd2, 8'hFF);
    expStat(8'hFC, "R7_user_write");
    slvWrite(2'd1, 8'h11);
    expStat(8'hFD, "R6_obf_again");
    slvWrite(2'd2, 8'hA5);
    expStat(8'hAD, "R8_write1_keeps");
    slvWrite(2'd2, 8'h04);
    expStat(8'h0C, "R8_write0_clears");

    fork
      hostAcc(1, 0, 8'h33, 12, 1, 0, 0);
      begin repeat (6) @(negedge clk); slvRead(2'd0, v); end
    join
    expStat(8'h04, "R9_long_strobe_once");
    slvRead(2'd0, v);
    chk(v == 8'h33, "R9_in_long", v, 8'h33);

    hostAcc(1, 1, 8'hEE, 4, 0, 0, 0);
    expStat(8'h04, "R9_cs_high_ignored");
    slvRead(2'd0, v);
    chk(v == 8'h33, "R9_in_unchanged", v, 8'h33);

    fork
      hostAcc(1, 1, 8'h77, 4, 1, 0, 0);
      begin repeat (2) @(negedge clk); slvRead(2'd0, v); end
    join
    expStat(8'h0E, "R5_collision_set_wins");

    fork
      hostAcc(0, 0, 8'h00, 4, 1, 0, 0);
      begin repeat (2) @(negedge clk); slvWrite(2'd1, 8'h42); end
    join
    expStat(8'h0F, "R6_collision_set_wins");
    hostAcc(0, 0, 8'h00, 4, 1, 1, 8'h42);
    expStat(8'h0E, "R6_final_clear");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
    join_any
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule